// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block is the arithmetic core of a small 8-bit controller datapath. It holds an accumulator, a second operand register and a status byte. Each cycle it can run one operation: add, add with carry, subtract with borrow, an unsigned multiply of the accumulator by the second register, or an unsigned divide of the accumulator by the second register. Add-type operations take their second operand from a separate source bus. Multiply and divide spread their two-part results across both registers.

The status byte carries the arithmetic flags. It also holds two bank-select bits, whose value is also given as a register-file base address, and two free user flags. Software loads the accumulator, the second register and the status byte through plain write strobes. An operation in the same cycle takes precedence over those strobes. The parity bit is not stored from software. It follows the accumulator on every cycle.

Top module: `acc_flag_alu`

## Requirements
- R1: Operation code 4 (multiply) forms the unsigned product of A and B. The upper half goes to B and the lower half to A. Carry is cleared, and overflow is set exactly when the product exceeds 255.
- R2: Operation code 5 (divide) with B nonzero writes the quotient A/B to A and the remainder to B, and clears both carry and overflow.
- R3: Operation code 5 with B equal to zero sets overflow and clears carry. A and B keep their previous values.
- R4: Operation code 1 (add) writes A+src to A and code 2 (add with carry) writes A+src+carry to A. Carry is the carry out of bit 7.
- R5: Operation code 3 (subtract with borrow) writes A-src-carry to A. Carry is set on a borrow into bit 7 and cleared otherwise.
- R6: For codes 1 to 3, auxiliary carry is set on a carry from bit 3 into bit 4 (add), or on a borrow into bit 3 (subtract). Multiply and divide leave it unchanged.
- R7: For codes 1 to 3, overflow is set exactly when the signed result lies outside -128..+127.
- R8: Status bit 0 always makes the count of ones in {A, bit 0} even, including directly after an accumulator write.
- R9: Status layout, from bit 7 down to bit 0: carry, aux carry, user flag 0, bank select 1, bank select 0, overflow, user flag 1, parity. The status write port loads bits 7..1, and bit 0 written through the port has no effect.
- R10: The bank base output equals the 2-bit bank select {bit 4, bit 3} times 8.
- R11: After reset, A, B and the status byte are all zero.
- R12: While an operation is requested, all three write strobes are ignored. Codes 0, 6 and 7 change nothing. With no operation and no strobe, A, B and the status byte hold their values. Codes 1 to 3 leave B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Run the operation on op_i this cycle |
| op_i | input | 3 | Operation code |
| src_i | input | DATA_W | Second operand for codes 1 to 3 |
| acc_wr_i | input | 1 | Load A from acc_data_i |
| acc_data_i | input | DATA_W | A load value |
| b_wr_i | input | 1 | Load B from b_data_i |
| b_data_i | input | DATA_W | B load value |
| st_wr_i | input | 1 | Load status bits 7..1 from st_data_i |
| st_data_i | input | 8 | Status load value |
| acc_o | output | DATA_W | Accumulator |
| b_o | output | DATA_W | Second register |
| st_o | output | 8 | Status byte |
| bank_base_o | output | 2+log2(BANK_REGS) | Base address of the selected register bank |

## Verification
The bench builds the block with its defaults: an 8-bit datapath and 8 registers per bank. At this width the signed boundaries 0x7F and 0x80 and the full-scale product 0xFF*0xFF can be reached directly. The nibble-carry edge of the auxiliary flag can also be hit with hand-picked operands. A 5-bit bank base lets every bank-select setting be checked against the multiples of 8.

// File: rtl/aau_pkg.sv
package aau_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADDC = 3'd2,
    OP_SUBB = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } aau_op_e;

  localparam int ST_W   = 8;
  localparam int ST_CY  = 7;
  localparam int ST_AC  = 6;
  localparam int ST_F0  = 5;
  localparam int ST_RS1 = 4;
  localparam int ST_RS0 = 3;
  localparam int ST_OV  = 2;
  localparam int ST_UF1 = 1;
  localparam int ST_PAR = 0;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } aau_flags_t;
endpackage

// File: rtl/aau_addsub.sv
module aau_addsub #(
  parameter int DATA_W = 8
) (
  input  logic              [DATA_W-1:0] a_i,
  input  logic              [DATA_W-1:0] b_i,
  input  logic                           sub_i,
  input  logic                           use_cy_i,
  input  logic                           cy_i,
  output logic              [DATA_W-1:0] res_o,
  output aau_pkg::aau_flags_t            flags_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] opb;
  logic              cin;
  logic [DATA_W:0]   full;
  logic              c_half;
  logic              c_msb;

  assign opb  = sub_i ? ~b_i : b_i;
  // subtract as a + ~b + ~borrow_in
  assign cin  = sub_i ? ~(use_cy_i & cy_i) : (use_cy_i & cy_i);
  assign full = {1'b0, a_i} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};

  assign c_half = a_i[HALF] ^ opb[HALF] ^ full[HALF];
  assign c_msb  = a_i[DATA_W-1] ^ opb[DATA_W-1] ^ full[DATA_W-1];

  assign res_o      = full[DATA_W-1:0];
  assign flags_o.cy = full[DATA_W] ^ sub_i;
  assign flags_o.ac = c_half ^ sub_i;
  assign flags_o.ov = full[DATA_W] ^ c_msb;
endmodule

// File: rtl/aau_mul.sv
module aau_mul #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              wide_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;

  assign prod   = PROD_W'(a_i) * PROD_W'(b_i);
  assign hi_o   = prod[PROD_W-1:DATA_W];
  assign lo_o   = prod[DATA_W-1:0];
  assign wide_o = |prod[PROD_W-1:DATA_W];
endmodule

// File: rtl/aau_div.sv
module aau_div #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] rem_s [DATA_W+1];

  assign rem_s[0] = '0;

  // restoring divider, one stage per quotient bit, msb first
  for (genvar k = 0; k < DATA_W; k++) begin : g_stage
    localparam int BIT = DATA_W - 1 - k;
    logic [DATA_W:0] trial;
    logic [DATA_W:0] diff;

    assign trial        = {rem_s[k], a_i[BIT]};
    assign diff         = trial - {1'b0, b_i};
    assign quo_o[BIT]   = ~diff[DATA_W];
    assign rem_s[k+1]   = diff[DATA_W] ? trial[DATA_W-1:0] : diff[DATA_W-1:0];
  end

  assign rem_o  = rem_s[DATA_W];
  assign zero_o = (b_i == '0);
endmodule

// File: rtl/aau_status.sv
module aau_status
  import aau_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ST_W-1:1]       wr_data_i,
  input  logic                  upd_cy_i,
  input  logic                  upd_ac_i,
  input  logic                  upd_ov_i,
  input  aau_flags_t            flags_i,
  input  logic                  parity_next_i,
  output logic [ST_W-1:0]       st_o
);
  logic [ST_W-1:1] st_q;
  logic            par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (wr_en_i) begin
      st_q <= wr_data_i;
    end else begin
      if (upd_cy_i) st_q[ST_CY] <= flags_i.cy;
      if (upd_ac_i) st_q[ST_AC] <= flags_i.ac;
      if (upd_ov_i) st_q[ST_OV] <= flags_i.ov;
    end
  end

  // parity tracks the next accumulator value every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= parity_next_i;
  end

  assign st_o = {st_q, par_q};
endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import aau_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BANK_REGS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 op_valid_i,
  input  logic [2:0]           op_i,
  input  logic [DATA_W-1:0]    src_i,
  input  logic                 acc_wr_i,
  input  logic [DATA_W-1:0]    acc_data_i,
  input  logic                 b_wr_i,
  input  logic [DATA_W-1:0]    b_data_i,
  input  logic                 st_wr_i,
  input  logic [7:0]           st_data_i,
  output logic [DATA_W-1:0]    acc_o,
  output logic [DATA_W-1:0]    b_o,
  output logic [7:0]           st_o,
  output logic [1+$clog2(BANK_REGS):0] bank_base_o
);
  localparam int BANK_SH = $clog2(BANK_REGS);
  localparam int PROD_W  = 2 * DATA_W;

  logic [DATA_W-1:0] acc_q, b_q, acc_d, b_d;
  logic [ST_W-1:0]   st;

  logic is_add, is_addc, is_subb, is_mul, is_div, is_arith;

  assign is_add   = op_valid_i && (op_i == OP_ADD);
  assign is_addc  = op_valid_i && (op_i == OP_ADDC);
  assign is_subb  = op_valid_i && (op_i == OP_SUBB);
  assign is_mul   = op_valid_i && (op_i == OP_MUL);
  assign is_div   = op_valid_i && (op_i == OP_DIV);
  assign is_arith = is_add | is_addc | is_subb;

  logic [DATA_W-1:0] as_res;
  aau_flags_t        as_flags;

  aau_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i      (acc_q),
    .b_i      (src_i),
    .sub_i    (is_subb),
    .use_cy_i (is_addc | is_subb),
    .cy_i     (st[ST_CY]),
    .res_o    (as_res),
    .flags_o  (as_flags)
  );

  logic [DATA_W-1:0] mul_hi, mul_lo;
  logic              mul_wide;

  aau_mul #(.DATA_W(DATA_W)) u_mul (
    .a_i    (acc_q),
    .b_i    (b_q),
    .hi_o   (mul_hi),
    .lo_o   (mul_lo),
    .wide_o (mul_wide)
  );

  logic [DATA_W-1:0] div_quo, div_rem;
  logic              div_zero;

  aau_div #(.DATA_W(DATA_W)) u_div (
    .a_i    (acc_q),
    .b_i    (b_q),
    .quo_o  (div_quo),
    .rem_o  (div_rem),
    .zero_o (div_zero)
  );

  always_comb begin
    acc_d = acc_q;
    b_d   = b_q;
    if (op_valid_i) begin
      if (is_arith) begin
        acc_d = as_res;
      end else if (is_mul) begin
        acc_d = mul_lo;
        b_d   = mul_hi;
      end else if (is_div && !div_zero) begin
        acc_d = div_quo;
        b_d   = div_rem;
      end
    end else begin
      if (acc_wr_i) acc_d = acc_data_i;
      if (b_wr_i)   b_d   = b_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      b_q   <= '0;
    end else begin
      acc_q <= acc_d;
      b_q   <= b_d;
    end
  end

  aau_flags_t st_flags;

  always_comb begin
    st_flags = as_flags;
    if (is_mul) begin
      st_flags.cy = 1'b0;
      st_flags.ov = mul_wide;
    end else if (is_div) begin
      st_flags.cy = 1'b0;
      st_flags.ov = div_zero;
    end
  end

  logic unused_par_wr;
  assign unused_par_wr = st_data_i[ST_PAR];

  aau_status u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (st_wr_i & ~op_valid_i),
    .wr_data_i     (st_data_i[ST_W-1:1]),
    .upd_cy_i      (is_arith | is_mul | is_div),
    .upd_ac_i      (is_arith),
    .upd_ov_i      (is_arith | is_mul | is_div),
    .flags_i       (st_flags),
    .parity_next_i (^acc_d),
    .st_o          (st)
  );

  assign acc_o       = acc_q;
  assign b_o         = b_q;
  assign st_o        = st;
  assign bank_base_o = {st[ST_RS1], st[ST_RS0], {BANK_SH{1'b0}}};

  AST_MUL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mul |=> ({b_q, acc_q} == PROD_W'(PROD_W'($past(acc_q)) * PROD_W'($past(b_q))))
      && !st[ST_CY]); // R1

  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_div && b_q == '0) |=> st[ST_OV] && !st[ST_CY] && $stable(acc_q) && $stable(b_q)); // R3

  AST_PARITY_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(^{acc_q, st[ST_PAR]})); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !acc_wr_i && !b_wr_i && !st_wr_i)
      |=> $stable(acc_q) && $stable(b_q) && $stable(st[ST_W-1:1])); // R12

  AST_OP_BLOCKS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_arith |=> $stable(b_q)); // R12
endmodule

// File: tb/acc_flag_alu_bench.sv
`timescale 1ns/1ps
module acc_flag_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] src = '0;
  logic       acc_wr = 1'b0, b_wr = 1'b0, st_wr = 1'b0;
  logic [7:0] acc_data = '0, b_data = '0, st_data = '0;
  logic [7:0] acc, b, st;
  logic [4:0] bank_base;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  acc_flag_alu u_acc_flag_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .src_i(src),
    .acc_wr_i(acc_wr), .acc_data_i(acc_data), .b_wr_i(b_wr), .b_data_i(b_data),
    .st_wr_i(st_wr), .st_data_i(st_data), .acc_o(acc), .b_o(b), .st_o(st),
    .bank_base_o(bank_base)
  );

  function automatic logic [23:0] model(input int opc, input int a, input int bb,
                                        input int s, input int sr);
    int r, sa, ss, sres, c, na, nb, ns;
    na = a; nb = bb; ns = s & 8'hFE;
    sa = (a >= 128) ? a - 256 : a;
    ss = (sr >= 128) ? sr - 256 : sr;
    c  = (s >> 7) & 1;
    case (opc)
      1, 2: begin
        if (opc == 1) c = 0;
        r = a + sr + c; sres = sa + ss + c;
        na = r & 255;
        ns = (ns & 8'h3A) | ((r > 255) ? 8'h80 : 0)
           | ((((a & 15) + (sr & 15) + c) > 15) ? 8'h40 : 0)
           | ((sres > 127 || sres < -128) ? 8'h04 : 0);
      end
      3: begin
        r = a - sr - c; sres = sa - ss - c;
        na = r & 255;
        ns = (ns & 8'h3A) | ((r < 0) ? 8'h80 : 0)
           | (((a & 15) < ((sr & 15) + c)) ? 8'h40 : 0)
           | ((sres > 127 || sres < -128) ? 8'h04 : 0);
      end
      4: begin
        r = a * bb; na = r & 255; nb = r >> 8;
        ns = (ns & 8'h7A) | ((r > 255) ? 8'h04 : 0);
      end
      5: begin
        if (bb == 0) ns = (ns & 8'h7A) | 8'h04;
        else begin na = a / bb; nb = a % bb; ns = ns & 8'h7A; end
      end
      default: ;
    endcase
    ns = ns | ((^na[7:0]) ? 1 : 0);
    return {na[7:0], nb[7:0], ns[7:0]};
  endfunction

  task automatic chk8(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [23:0] e);
    chk8(req, "acc", acc, e[23:16]);
    chk8(req, "b",   b,   e[15:8]);
    chk8(req, "st",  st,  e[7:0]);
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] bb, input logic [7:0] s);
    @(negedge clk);
    acc_wr = 1; acc_data = a; b_wr = 1; b_data = bb; st_wr = 1; st_data = s;
    @(negedge clk);
    acc_wr = 0; b_wr = 0; st_wr = 0;
  endtask

  task automatic run(input string req, input int opc, input int a, input int bb,
                     input int s, input int sr);
    load(a[7:0], bb[7:0], s[7:0]);
    op_valid = 1; op = opc[2:0]; src = sr[7:0];
    @(negedge clk);
    op_valid = 0;
    chk_all(req, model(opc, a, bb, s, sr));
  endtask

  task automatic t_reset;
    chk8("R11", "acc", acc, 8'h00);
    chk8("R11", "b", b, 8'h00);
    chk8("R11", "st", st, 8'h00);
    chk8("R11", "bank", {3'b0, bank_base}, 8'h00);
  endtask

  task automatic t_status_port;
    load(8'h01, 8'h00, 8'hFE);
    chk8("R9", "st parity from acc", st, 8'hFF);
    load(8'h03, 8'h00, 8'h01);
    chk8("R9", "st bit0 write ignored", st, 8'h00);
    for (int i = 0; i < 4; i++) begin
      load(8'h00, 8'h00, 8'(i << 3));
      chk8("R10", "bank base", {3'b0, bank_base}, 8'(i * 8));
    end
    load(8'h80, 8'h00, 8'h00);
    chk8("R8", "parity after acc write", st, 8'h01);
  endtask

  task automatic t_add;
    run("R4", 1, 8'h7F, 0, 0, 8'h01);
    run("R7", 1, 8'h80, 0, 0, 8'h80);
    run("R4", 1, 8'hFF, 0, 0, 8'h01);
    run("R6", 1, 8'h0F, 0, 8'h80, 8'h01);
    run("R4", 2, 8'hFF, 0, 8'h80, 8'h00);
    run("R4", 2, 8'h7F, 0, 8'h80, 8'h00);
    run("R4", 2, 8'h10, 0, 8'h00, 8'h20);
  endtask

  task automatic t_subb;
    run("R5", 3, 8'h80, 0, 0, 8'h01);
    run("R5", 3, 8'h00, 0, 8'h80, 8'h00);
    run("R6", 3, 8'h10, 0, 0, 8'h01);
    run("R7", 3, 8'h7F, 0, 0, 8'hFF);
    run("R5", 3, 8'h55, 0, 8'h80, 8'h55);
  endtask

  task automatic t_mul;
    run("R1", 4, 8'hFF, 8'hFF, 8'hC0, 0);
    run("R1", 4, 8'h10, 8'h0F, 8'h84, 0);
    run("R1", 4, 8'h80, 8'h02, 8'h78, 0);
    run("R1", 4, 8'h00, 8'h7F, 0, 0);
  endtask

  task automatic t_div;
    run("R2", 5, 8'hFF, 8'h10, 8'h84, 0);
    run("R2", 5, 8'h7F, 8'hFF, 8'h80, 0);
    run("R2", 5, 8'h80, 8'h01, 8'h44, 0);
    run("R3", 5, 8'h5A, 8'h00, 8'h80, 0);
    run("R3", 5, 8'h00, 8'h00, 8'h40, 0);
  endtask

  task automatic t_precedence;
    load(8'h10, 8'h20, 8'h00);
    op_valid = 1; op = 3'd1; src = 8'h01;
    acc_wr = 1; acc_data = 8'h99; b_wr = 1; b_data = 8'h77; st_wr = 1; st_data = 8'hFE;
    @(negedge clk);
    op_valid = 0; acc_wr = 0; b_wr = 0; st_wr = 0;
    chk_all("R12", {8'h11, 8'h20, 8'h00});
    load(8'h33, 8'h44, 8'hA4);
    op_valid = 1; op = 3'd6; acc_wr = 1; acc_data = 8'h01;
    @(negedge clk);
    op = 3'd0;
    @(negedge clk);
    op_valid = 0; acc_wr = 0;
    chk_all("R12", {8'h33, 8'h44, 8'hA4});
    acc_data = 8'hEE; b_data = 8'hDD; st_data = 8'h00; src = 8'h55;
    repeat (3) @(negedge clk);
    chk_all("R12", {8'h33, 8'h44, 8'hA4});
  endtask

  task automatic t_random;
    int corner[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 300; i++) begin
      int a, bb, s, sr, opc;
      opc = 1 + int'($urandom_range(0, 4));
      a   = (i % 3 == 0) ? corner[$urandom_range(0, 3)] : int'($urandom_range(0, 255));
      bb  = (i % 5 == 0) ? corner[$urandom_range(0, 3)] : int'($urandom_range(0, 255));
      sr  = (i % 4 == 0) ? corner[$urandom_range(0, 3)] : int'($urandom_range(0, 255));
      s   = int'($urandom_range(0, 255));
      run((opc == 4) ? "R1" : (opc == 5) ? "R2" : (opc == 3) ? "R5" : "R4", opc, a, bb, s, sr);
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_status_port;
    t_add;
    t_subb;
    t_mul;
    t_div;
    t_precedence;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule